// File: doc/BRIEF.md
# ADC Conversion Result Bank with Offset Post-Processing

This block stores the outcome of analog-to-digital conversions and presents them on a small read port. There are sixteen raw slots, one for each conversion channel. A completed conversion writes its 16-bit code into the slot for its channel. There are also four post-processing units. Each unit follows one channel, chosen by a 4-bit select input, and subtracts a supplied offset or reference value from that channel's fresh raw code. The unit keeps the signed difference as a sign-extended 32-bit word.

A resolution input picks full 16-bit arithmetic or 12-bit arithmetic. The block samples it when the conversion lands. In 12-bit mode only the low twelve bits of the raw code and of the offset take part. Software, or a neighbouring block, reads any stored word through a word-addressed port. Read data is registered and appears one clock after the request.

Top module: `adc_result_bank`

## Requirements
- R1: A conversion strobe (`conv_valid` high at a clock edge) with channel `conv_chan` = n writes `conv_data` into raw slot n at that edge. All other slots keep their values.
- R2: A read of word address n (0 to 15) returns raw slot n, zero-extended to 32 bits. Read data appears on `rd_data` after the clock edge that samples `rd_en` high, and it holds while `rd_en` is low.
- R3: In 16-bit mode (`res_mode` = 0), a unit's result is raw minus offset, computed as a 17-bit two's-complement value in bits 16:0. Bits 31:16 all equal bit 16. No saturation is applied.
- R4: In 12-bit mode (`res_mode` = 1), the result is raw[11:0] minus offset[11:0], computed as a 13-bit two's-complement value in bits 12:0. Bits 31:12 all equal bit 12.
- R5: A unit's result changes exactly one clock after the raw slot it follows is written. A read sampled at that same later edge still returns the previous result.
- R6: Unit k follows only the channel on `ppu_sel[4k+3:4k]`. Conversions on other channels leave its result unchanged.
- R7: The resolution used for a result is the value of `res_mode` at the edge that wrote the raw slot. A later change of `res_mode` does not alter that result.
- R8: A read sampled at the same edge as a raw-slot write returns the value the slot held before the write.
- R9: Unit k's result is read at word address 16 + 2k (16, 18, 20, 22). Reads of addresses 17, 19, 21, 23 and 24 to 31 return zero and change no stored value.
- R10: A synchronous active-low reset clears every raw slot, every unit result and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_valid | input | 1 | Conversion-complete strobe |
| conv_chan | input | 4 | Channel of the completed conversion |
| conv_data | input | 16 | Raw conversion code |
| res_mode | input | 1 | 0 = 16-bit arithmetic, 1 = 12-bit arithmetic |
| ppu_sel | input | 16 | Four 4-bit channel selects, unit k in bits 4k+3:4k |
| ppu_offset | input | 64 | Four 16-bit offsets, unit k in bits 16k+15:16k |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Word address of the read |
| rd_data | output | 32 | Registered read data |

## Verification
Two events can land on the same clock edge: a raw-slot write and a bus read of that slot. A unit's delayed update can also coincide with a read of its result. The bench provokes the first case by raising the conversion strobe and the read request for channel 7 in the same cycle. It then expects the old slot contents, followed by the new contents on the next read. For the second case, the bench reads a unit's result in the first cycle after a conversion and expects the previous difference. One cycle later it expects the new difference.

// File: rtl/adc_rb_pkg.sv
// Package: shared sizes and the resolution encoding for the result bank.
// Assumes one conversion per clock at most.
package adc_rb_pkg;
    localparam int RAW_W      = 16;
    localparam int LO_W       = 12;
    localparam int WORD_W     = 32;
    localparam int NUM_SLOTS  = 16;
    localparam int NUM_PPU    = 4;
    localparam int CH_W       = $clog2(NUM_SLOTS);
    localparam int ADDR_W     = 5;
    localparam int PPU_BASE   = NUM_SLOTS;
    localparam int PPU_STRIDE = 2;

    typedef enum logic {
        RES_FULL = 1'b0,
        RES_LOW  = 1'b1
    } res_mode_e;
endpackage

// File: rtl/adc_raw_slots.sv
// Raw slot array: one register per conversion channel, written by the
// conversion strobe. Assumes conv_chan < NUM_SLOTS.
module adc_raw_slots
    import adc_rb_pkg::*;
#(
    parameter int N_SLOT = NUM_SLOTS,
    parameter int DW     = RAW_W,
    localparam int CW    = $clog2(N_SLOT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CW-1:0]              wr_chan,
    input  logic [DW-1:0]              wr_data,
    output logic [N_SLOT-1:0][DW-1:0]  slot_q
);
    for (genvar n = 0; n < N_SLOT; n++) begin : g_slot
        // Capture the conversion code when this slot's channel completes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[n] <= '0;
            else if (wr_en && wr_chan == CW'(n))
                slot_q[n] <= wr_data;
        end

        // R1
        slot_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(slot_q[n]) |-> ($past(wr_en) && $past(wr_chan) == CW'(n)));
    end
endmodule

// File: rtl/adc_ppu.sv
// One post-processing unit: follows a selected raw slot and, one clock
// after that slot is written, stores raw minus offset as a sign-extended
// word. The resolution is sampled with the conversion; the offset is
// taken when the result is written (it is expected to be quasi-static).
module adc_ppu
    import adc_rb_pkg::*;
#(
    parameter int N_SLOT = NUM_SLOTS,
    parameter int DW     = RAW_W,
    parameter int LW     = LO_W,
    parameter int OW     = WORD_W,
    localparam int CW    = $clog2(N_SLOT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       conv_valid,
    input  logic [CW-1:0]              conv_chan,
    input  logic                       res_mode,
    input  logic [CW-1:0]              sel,
    input  logic [DW-1:0]              offset,
    input  logic [N_SLOT-1:0][DW-1:0]  slots,
    output logic [OW-1:0]              result
);
    logic            hit_q;
    logic [CW-1:0]   sel_q;
    res_mode_e       mode_q;
    logic [DW-1:0]   src;
    logic [DW:0]     diff_full;
    logic [LW:0]     diff_low;
    logic [OW-1:0]   result_d;

    // Remember that the followed slot is being written, and with which mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            sel_q  <= '0;
            mode_q <= RES_FULL;
        end else begin
            hit_q  <= conv_valid && (conv_chan == sel);
            sel_q  <= sel;
            mode_q <= res_mode_e'(res_mode);
        end
    end

    // Form both differences and sign-extend the one the sampled mode picks.
    always_comb begin
        src       = slots[sel_q];
        diff_full = {1'b0, src} - {1'b0, offset};
        diff_low  = {1'b0, src[LW-1:0]} - {1'b0, offset[LW-1:0]};
        if (mode_q == RES_LOW)
            result_d = {{(OW-LW-1){diff_low[LW]}}, diff_low};
        else
            result_d = {{(OW-DW-1){diff_full[DW]}}, diff_full};
    end

    // Post the difference one clock after the raw slot update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (hit_q)
            result <= result_d;
    end

    // R5
    ppu_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> ($past(conv_valid, 2) && $past(conv_chan, 2) == $past(sel, 2)));

    // R3
    ppu_ext_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&result[OW-1:DW]) || !(|result[OW-1:DW]));

    // R4
    ppu_ext_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(result) && $past(res_mode, 2)) |-> ((&result[OW-1:LW]) || !(|result[OW-1:LW])));
endmodule

// File: rtl/adc_read_port.sv
// Registered read port: decodes a word address onto raw slots and unit
// results; unmapped addresses read as zero. Data loads only on rd_en.
module adc_read_port
    import adc_rb_pkg::*;
#(
    parameter int N_SLOT = NUM_SLOTS,
    parameter int N_PPU  = NUM_PPU,
    parameter int DW     = RAW_W,
    parameter int OW     = WORD_W,
    parameter int AW     = ADDR_W,
    parameter int BASE   = PPU_BASE,
    parameter int STRIDE = PPU_STRIDE,
    localparam int TOP_A = BASE + STRIDE * N_PPU
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [AW-1:0]              rd_addr,
    input  logic [N_SLOT-1:0][DW-1:0]  slots,
    input  logic [N_PPU-1:0][OW-1:0]   ppu_res,
    output logic [OW-1:0]              rd_data
);
    logic [OW-1:0] word;

    // Address decode onto the stored words.
    always_comb begin
        word = '0;
        for (int n = 0; n < N_SLOT; n++)
            if (rd_addr == AW'(n))
                word = {{(OW-DW){1'b0}}, slots[n]};
        for (int k = 0; k < N_PPU; k++)
            if (rd_addr == AW'(BASE + STRIDE * k))
                word = ppu_res[k];
    end

    // Register the selected word when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= word;
    end

    // R9
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr >= AW'(TOP_A)) |=> (rd_data == '0));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R10
    rd_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));
endmodule

// File: rtl/adc_result_bank.sv
// Top: raw slot array, a generated row of post-processing units, and the
// registered read port. Assumes at most one conversion strobe per clock.
module adc_result_bank
    import adc_rb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     conv_valid,
    input  logic [CH_W-1:0]          conv_chan,
    input  logic [RAW_W-1:0]         conv_data,
    input  logic                     res_mode,
    input  logic [NUM_PPU*CH_W-1:0]  ppu_sel,
    input  logic [NUM_PPU*RAW_W-1:0] ppu_offset,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [WORD_W-1:0]        rd_data
);
    logic [NUM_SLOTS-1:0][RAW_W-1:0] slot_q;
    logic [NUM_PPU-1:0][WORD_W-1:0]  ppu_res;

    adc_raw_slots u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (conv_valid),
        .wr_chan (conv_chan),
        .wr_data (conv_data),
        .slot_q  (slot_q)
    );

    for (genvar k = 0; k < NUM_PPU; k++) begin : g_ppu
        adc_ppu u_ppu (
            .clk        (clk),
            .rst_n      (rst_n),
            .conv_valid (conv_valid),
            .conv_chan  (conv_chan),
            .res_mode   (res_mode),
            .sel        (ppu_sel[k*CH_W +: CH_W]),
            .offset     (ppu_offset[k*RAW_W +: RAW_W]),
            .slots      (slot_q),
            .result     (ppu_res[k])
        );
    end

    adc_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .slots   (slot_q),
        .ppu_res (ppu_res),
        .rd_data (rd_data)
    );
endmodule

// File: tb/adc_result_bank_bench.sv
module adc_result_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [3:0]  conv_chan = '0;
    logic [15:0] conv_data = '0;
    logic        res_mode = 1'b0;
    logic [15:0] ppu_sel = '0;
    logic [63:0] ppu_offset = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [31:0] got;

    always #10 clk = ~clk;

    adc_result_bank u_adc_result_bank (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_chan(conv_chan),
        .conv_data(conv_data), .res_mode(res_mode), .ppu_sel(ppu_sel),
        .ppu_offset(ppu_offset), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [15:0] data;
        logic [15:0] off;
        logic        mode;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{16'h1234, 16'h0034, 1'b0, 32'h0000_1200},
        '{16'h0000, 16'h0001, 1'b0, 32'hFFFF_FFFF},
        '{16'hFFFF, 16'h0000, 1'b0, 32'h0000_FFFF},
        '{16'h0000, 16'hFFFF, 1'b0, 32'hFFFF_0001},
        '{16'h0FFF, 16'h0000, 1'b1, 32'h0000_0FFF},
        '{16'h0000, 16'h0FFF, 1'b1, 32'hFFFF_F001},
        '{16'h0800, 16'h0100, 1'b1, 32'h0000_0700},
        '{16'h0100, 16'h0800, 1'b1, 32'hFFFF_F900}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic conv(input logic [3:0] ch, input logic [15:0] d);
        @(negedge clk);
        conv_valid = 1'b1; conv_chan = ch; conv_data = d;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: everything reads zero after reset
        rd(5'd0, got);  chk("R10", got, 32'h0);
        rd(5'd16, got); chk("R10", got, 32'h0);
        rd(5'd22, got); chk("R10", got, 32'h0);

        ppu_sel = {4'd15, 4'd9, 4'd5, 4'd3};
        ppu_offset = {16'h0005, 16'h0000, 16'h0010, 16'h0000};

        // R1 R2 R3 R4: table walk on unit 0 following channel 3
        for (int i = 0; i < 8; i++) begin
            ppu_offset[15:0] = VEC[i].off;
            res_mode = VEC[i].mode;
            conv(4'd3, VEC[i].data);
            rd(5'd3, got);  chk("R1/R2", got, {16'h0, VEC[i].data});
            rd(5'd16, got); chk(VEC[i].mode ? "R4" : "R3", got, VEC[i].exp);
        end

        // R5: one-clock lag of the unit behind the raw slot
        res_mode = 1'b0; ppu_offset[15:0] = 16'h0000;
        conv(4'd3, 16'h00AB);
        rd(5'd16, got); chk("R5", got, 32'hFFFF_F900);
        rd(5'd16, got); chk("R5", got, 32'h0000_00AB);

        // R6: other channels do not move unit 0; units 1 and 3 follow theirs
        conv(4'd4, 16'hAAAA);
        rd(5'd4, got);  chk("R6", got, 32'h0000_AAAA);
        rd(5'd16, got); chk("R6", got, 32'h0000_00AB);
        conv(4'd5, 16'h0020);
        rd(5'd5, got);  rd(5'd18, got); chk("R6", got, 32'h0000_0010);
        conv(4'd15, 16'h0003);
        rd(5'd15, got); rd(5'd22, got); chk("R3", got, 32'hFFFF_FFFE);

        // R7: mode flipped right after the conversion does not apply
        res_mode = 1'b0;
        @(negedge clk);
        conv_valid = 1'b1; conv_chan = 4'd3; conv_data = 16'h1800;
        @(negedge clk);
        conv_valid = 1'b0; res_mode = 1'b1;
        rd(5'd3, got);
        rd(5'd16, got); chk("R7", got, 32'h0000_1800);
        res_mode = 1'b0;

        // R8: read and write of slot 7 in the same cycle
        conv(4'd7, 16'h1111);
        @(negedge clk);
        conv_valid = 1'b1; conv_chan = 4'd7; conv_data = 16'h2222;
        rd_en = 1'b1; rd_addr = 5'd7;
        @(negedge clk);
        conv_valid = 1'b0; rd_en = 1'b0;
        chk("R8", rd_data, 32'h0000_1111);
        rd(5'd7, got); chk("R8", got, 32'h0000_2222);

        // R2: rd_data holds while rd_en is low
        conv(4'd7, 16'h3333);
        chk("R2", rd_data, 32'h0000_2222);

        // R9: gaps and addresses above the map read zero, no side effect
        rd(5'd17, got); chk("R9", got, 32'h0);
        rd(5'd23, got); chk("R9", got, 32'h0);
        rd(5'd24, got); chk("R9", got, 32'h0);
        rd(5'd31, got); chk("R9", got, 32'h0);
        rd(5'd16, got); chk("R9", got, 32'h0000_1800);

        // R10: reset in mid-run clears slots and units
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10", rd_data, 32'h0);
        rd(5'd7, got);  chk("R10", got, 32'h0);
        rd(5'd22, got); chk("R10", got, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule